// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It holds a program counter, a register file with 32 entries, and small internal instruction and data word arrays. Each cycle it fetches the word at the program counter and decodes it into datapath controls. It reads two registers, extends the 16-bit immediate, runs the ALU and, when the instruction calls for it, reads or writes the data array. On the same edge it writes the result back and advances the program counter.

The two memory arrays are filled through a load port while the core is held in reset. The load port is valid/ready: `ld_ready` is high only while `rst_n` is low. A word offered with `ld_valid` while `ld_ready` is low is dropped, and nothing is buffered. Once reset is released, the core runs from address 0. The write-back and store activity appear on plain observation outputs, so a program can be followed one cycle at a time.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc` is 0, every register reads as 0 and `ld_ready` is 1. An accepted load word goes to the instruction array when `ld_to_imem`=1 and to the data array otherwise, at word index `ld_addr`. After reset is released, `ld_ready` is 0.
- R2: When opcode [31:26] is 0, the function field [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor. The result is written to the register named in bits [15:11].
- R3: Opcodes 0x08 (add), 0x0c (and), 0x0d (or) and 0x0e (xor) combine the register named in [25:21] with the immediate in [15:0] and write the register named in [20:16]. The 0x08 immediate is sign-extended; the other three are zero-extended.
- R4: Function 0x2a and opcode 0x0a write 1 when the first operand is less than the second as signed two's complement numbers, and 0 otherwise. Opcode 0x0a sign-extends its immediate.
- R5: Opcode 0x23 writes to register [20:16] the data word at index bits [7:2] of (register [25:21] plus the sign-extended immediate). In general, the data index is address bits [log2(DMEM_WORDS)+1:2].
- R6: Opcode 0x2b stores register [20:16] at that same address. It raises `dm_we` with `dm_addr` and `dm_wdata` and writes no register.
- R7: Opcode 0x04 branches when the two registers are equal, and 0x05 branches when they differ. A taken branch goes to pc+4+(sign-extended immediate shifted left by 2); a branch that is not taken goes to pc+4. Neither writes a register or memory.
- R8: Opcode 0x02 sets pc to {pc[31:28], bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero. A write-back to it may show on `wb_en`, but it leaves the register unchanged.
- R10: Any other opcode, and any other function code under opcode 0, writes nothing and advances pc by 4.
- R11: Instructions are fetched from word index pc[log2(IMEM_WORDS)+1:2]. Every instruction other than a branch or jump advances pc by 4, so pc stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the load port |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load port accepts words (only in reset) |
| ld_to_imem | input | 1 | 1 selects the instruction array, 0 the data array |
| ld_addr | input | LDW | Word index of the load |
| ld_data | input | 32 | Load word |
| pc | output | 32 | Current program counter |
| wb_en | output | 1 | Register write this cycle |
| wb_addr | output | 5 | Destination register |
| wb_data | output | 32 | Write-back value |
| dm_we | output | 1 | Data store this cycle |
| dm_addr | output | 32 | Store byte address |
| dm_wdata | output | 32 | Store value |

## Verification
The hardest situations to create from the ports are back-to-back dependences on a just-written register, writes to register 0 that are read on the next cycle, and taken branches and jumps that land in freshly reached code. A random program draws its register numbers only from 0 to 7. This keeps producer/consumer pairs and register-0 traffic frequent. It also mixes short forward and backward branch offsets with jumps anywhere in the instruction array. A directed prologue forces the sign/zero extension, store-then-load, and taken/untaken branch cases first. A lockstep reference model in the bench predicts every cycle's outputs.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0a;
  localparam logic [5:0] OP_ANDI = 6'h0c;
  localparam logic [5:0] OP_ORI  = 6'h0d;
  localparam logic [5:0] OP_XORI = 6'h0e;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2b;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2a;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    sign_ext;
    logic    mem_to_reg;
    logic    mem_read;
    logic    mem_write;
    logic    reg_write;
    logic    branch;
    logic    branch_ne;
    logic    jump;
    logic    illegal;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (opcode)
      OP_REG: begin
        ctl.dst_rd    = 1'b1;
        ctl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_XOR:  ctl.alu_op = ALU_XOR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: begin
            ctl.reg_write = 1'b0;
            ctl.illegal   = 1'b1;
          end
        endcase
      end
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI: begin
        ctl.src_imm   = 1'b1;
        ctl.reg_write = 1'b1;
        ctl.sign_ext  = (opcode == OP_ADDI) || (opcode == OP_SLTI);
        case (opcode)
          OP_SLTI: ctl.alu_op = ALU_SLT;
          OP_ANDI: ctl.alu_op = ALU_AND;
          OP_ORI:  ctl.alu_op = ALU_OR;
          OP_XORI: ctl.alu_op = ALU_XOR;
          default: ctl.alu_op = ALU_ADD;
        endcase
      end
      OP_LW: begin
        ctl.src_imm    = 1'b1;
        ctl.sign_ext   = 1'b1;
        ctl.mem_read   = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_write  = 1'b1;
      end
      OP_SW: begin
        ctl.src_imm   = 1'b1;
        ctl.sign_ext  = 1'b1;
        ctl.mem_write = 1'b1;
      end
      OP_BEQ, OP_BNE: begin
        ctl.sign_ext  = 1'b1;
        ctl.branch    = 1'b1;
        ctl.branch_ne = (opcode == OP_BNE);
        ctl.alu_op    = ALU_SUB;
      end
      OP_JMP:  ctl.jump    = 1'b1;
      default: ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && wa == AW'(g))         regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa == '0) |=> (ra1 != '0 || rd1 == '0)); // R9
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    case (op)
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = W'($signed(a) < $signed(b));
      default: y = a + b;
    endcase
  end

  assign zero = (diff == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int XLEN = 32,
  localparam int IAW  = $clog2(IMEM_WORDS),
  localparam int DAW  = $clog2(DMEM_WORDS),
  localparam int LDW  = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_to_imem,
  input  logic [LDW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc,
  output logic            wb_en,
  output logic [4:0]      wb_addr,
  output logic [XLEN-1:0] wb_data,
  output logic            dm_we,
  output logic [XLEN-1:0] dm_addr,
  output logic [XLEN-1:0] dm_wdata
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, instr;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rdata;
  logic            alu_zero, br_taken, ld_fire;
  ctrl_t           ctl;

  assign ld_ready = !rst_n;
  assign ld_fire  = ld_valid && ld_ready;

  // fetch
  assign instr = imem[pc_q[IAW+1:2]];

  sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (instr[25:21]),
    .ra2   (instr[20:16]),
    .rd1   (rs_val),
    .rd2   (rt_val),
    .we    (wb_en),
    .wa    (wb_addr),
    .wd    (wb_data)
  );

  // immediate extender
  assign imm_ext = {{(XLEN-16){ctl.sign_ext & instr[15]}}, instr[15:0]};

  // datapath multiplexers
  assign alu_b   = ctl.src_imm ? imm_ext : rt_val;
  assign wb_addr = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctl.mem_to_reg ? mem_rdata : alu_y;
  assign wb_en   = ctl.reg_write;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory
  assign mem_rdata = dmem[alu_y[DAW+1:2]];
  assign dm_we     = ctl.mem_write;
  assign dm_addr   = alu_y;
  assign dm_wdata  = rt_val;

  always_ff @(posedge clk) begin
    if (ld_fire && ld_to_imem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_to_imem)      dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (rst_n && ctl.mem_write) dmem[alu_y[DAW+1:2]]   <= rt_val;
  end

  // next program counter
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_taken = ctl.branch && (alu_zero ^ ctl.branch_ne);

  always_comb begin
    if (ctl.jump)    pc_next = {pc_q[31:28], instr[25:0], 2'b00};
    else if (br_taken) pc_next = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    else             pc_next = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc = pc_q;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R11
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.branch && !ctl.jump) |=> pc == $past(pc) + XLEN'(4)); // R11
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jump |=> pc[27:0] == {$past(instr[25:0]), 2'b00}); // R8
  AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.illegal |-> (!wb_en && !dm_we)); // R10
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> !wb_en); // R6
  AST_LOAD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready); // R1
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int LW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, ld_valid, ld_to_imem, ld_ready;
  logic [LW-1:0] ld_addr;
  logic [31:0]   ld_data, pc, wb_data, dm_addr, dm_wdata;
  logic          wb_en, dm_we;
  logic [4:0]    wb_addr;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_to_imem(ld_to_imem), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc(pc), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_imem [IW];
  logic [31:0] m_dmem [DW];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  logic        e_wen, e_dwe, e_ctl;
  logic [4:0]  e_wa;
  logic [31:0] e_wd, e_da, e_dwd, e_npc;
  string       e_tag;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  function automatic logic [31:0] gen_instr();
    int k = $urandom_range(0, 19);
    int rs = $urandom_range(0, 7);
    int rt = $urandom_range(0, 7);
    int rd = $urandom_range(0, 7);
    logic [15:0] imm = 16'($urandom);
    logic [5:0] fns [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2a};
    logic [5:0] ops [5] = '{6'h08, 6'h0a, 6'h0c, 6'h0d, 6'h0e};
    int off = $urandom_range(0, 10) - 4;
    if (k < 6)   return enc_r(rs, rt, rd, fns[k]);
    if (k == 6)  return enc_r(rs, rt, rd, 6'h21);
    if (k < 12)  return enc_i(ops[k-7], rs, rt, imm);
    if (k < 14)  return enc_i(6'h23, rs, rt, imm);
    if (k < 16)  return enc_i(6'h2b, rs, rt, imm);
    if (k == 16) return enc_i(6'h04, rs, rt, 16'(off));
    if (k == 17) return enc_i(6'h05, rs, rt, 16'(off));
    if (k == 18) return enc_j($urandom_range(0, IW-1));
    return enc_i(6'h3f, rs, rt, imm);
  endfunction

  task automatic predict();
    logic [31:0] ins = m_imem[m_pc[7:2]];
    logic [5:0]  op  = ins[31:26];
    logic [5:0]  fn  = ins[5:0];
    logic [31:0] a   = m_reg[ins[25:21]];
    logic [31:0] b   = m_reg[ins[20:16]];
    logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] zx  = {16'h0, ins[15:0]};
    e_wen = 0; e_dwe = 0; e_ctl = 0; e_wa = ins[20:16]; e_wd = 0;
    e_da = 0; e_dwd = 0; e_npc = m_pc + 4; e_tag = "R10";
    case (op)
      6'h00: begin
        e_wa = ins[15:11]; e_wen = 1; e_tag = "R2";
        case (fn)
          6'h20: e_wd = a + b;
          6'h22: e_wd = a - b;
          6'h24: e_wd = a & b;
          6'h25: e_wd = a | b;
          6'h26: e_wd = a ^ b;
          6'h2a: begin e_wd = 32'($signed(a) < $signed(b)); e_tag = "R4"; end
          default: begin e_wen = 0; e_tag = "R10"; end
        endcase
      end
      6'h08: begin e_wen = 1; e_wd = a + sx; e_tag = "R3"; end
      6'h0a: begin e_wen = 1; e_wd = 32'($signed(a) < $signed(sx)); e_tag = "R4"; end
      6'h0c: begin e_wen = 1; e_wd = a & zx; e_tag = "R3"; end
      6'h0d: begin e_wen = 1; e_wd = a | zx; e_tag = "R3"; end
      6'h0e: begin e_wen = 1; e_wd = a ^ zx; e_tag = "R3"; end
      6'h23: begin e_wen = 1; e_wd = m_dmem[(a + sx) >> 2 & 32'(DW-1)]; e_tag = "R5"; end
      6'h2b: begin e_dwe = 1; e_da = a + sx; e_dwd = b; e_tag = "R6"; end
      6'h04, 6'h05: begin
        e_ctl = 1; e_tag = "R7";
        if ((a == b) ^ (op == 6'h05)) e_npc = m_pc + 4 + {sx[29:0], 2'b00};
      end
      6'h02: begin e_ctl = 1; e_tag = "R8"; e_npc = {m_pc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (e_wen && e_wa == 5'd0) e_tag = "R9";
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    string pc_tag;
    void'($urandom(32'd2024));
    rst_n = 0; ld_valid = 0; ld_to_imem = 0; ld_addr = '0; ld_data = '0;

    // directed prologue
    m_imem[0]  = enc_r(6, 5, 7, 6'h25);
    m_imem[1]  = enc_i(6'h08, 0, 1, 16'hffff);
    m_imem[2]  = enc_i(6'h0d, 0, 2, 16'hffff);
    m_imem[3]  = enc_r(1, 2, 3, 6'h2a);
    m_imem[4]  = enc_r(1, 1, 0, 6'h20);
    m_imem[5]  = enc_r(0, 2, 4, 6'h25);
    m_imem[6]  = enc_i(6'h3f, 1, 2, 16'h1234);
    m_imem[7]  = enc_i(6'h2b, 0, 2, 16'h0008);
    m_imem[8]  = enc_i(6'h23, 0, 5, 16'h0008);
    m_imem[9]  = enc_i(6'h04, 5, 2, 16'h0001);
    m_imem[10] = enc_i(6'h08, 0, 6, 16'h0001);
    m_imem[11] = enc_i(6'h05, 0, 0, 16'h0005);
    m_imem[12] = enc_j(14);
    m_imem[13] = enc_r(1, 1, 9, 6'h3f);
    for (int i = 14; i < IW; i++) m_imem[i] = gen_instr();
    for (int i = 0; i < DW; i++) m_dmem[i] = $urandom;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;

    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", pc, 32'h0);
    chk("R1", "ld_ready in reset", 32'(ld_ready), 32'h1);
    for (int i = 0; i < IW; i++) begin
      ld_valid = 1; ld_to_imem = 1; ld_addr = LW'(i); ld_data = m_imem[i];
      @(negedge clk);
    end
    for (int i = 0; i < DW; i++) begin
      ld_valid = 1; ld_to_imem = 0; ld_addr = LW'(i); ld_data = m_dmem[i];
      @(negedge clk);
    end
    ld_valid = 0;
    rst_n = 1;
    m_pc = 0;
    pc_tag = "R1";
    #1;
    chk("R1", "ld_ready after reset", 32'(ld_ready), 32'h0);

    for (int cyc = 0; cyc < 800; cyc++) begin
      chk(pc_tag, "pc", pc, m_pc);
      predict();
      if (cyc == 0) e_tag = "R1";
      chk(e_tag, "wb_en", 32'(wb_en), 32'(e_wen));
      if (e_wen) begin
        chk(e_tag, "wb_addr", 32'(wb_addr), 32'(e_wa));
        chk(e_tag, "wb_data", wb_data, e_wd);
      end
      chk(e_tag, "dm_we", 32'(dm_we), 32'(e_dwe));
      if (e_dwe) begin
        chk(e_tag, "dm_addr", dm_addr, e_da);
        chk(e_tag, "dm_wdata", dm_wdata, e_dwd);
      end
      if (e_wen && e_wa != 0) m_reg[e_wa] = e_wd;
      if (e_dwe) m_dmem[(e_da >> 2) & 32'(DW-1)] = e_dwd;
      pc_tag = e_ctl ? e_tag : "R11";
      m_pc = e_npc;
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule